// File: doc/BRIEF.md
# Four-Bank Clock Divider with Bypass and Output Enable

This block turns one fast source clock into nine divided clock outputs grouped in four banks: bank A (one output), bank B (one output), bank C (two outputs) and bank D (five outputs). Each bank has its own select bit that picks one of two even ratios. Every output is cut from one shared free-running 3-bit phase counter and then registered on the same source edge. As a result, the rising edges of all banks line up, and every output keeps a 50% duty cycle.

A single active-high control, `rst_oe`, holds every flip-flop in reset and disables all outputs. Driving it low restarts the phase counter and enables the outputs. When `div_en` is low, the divider is bypassed and every output follows a reference clock chosen by a two-way selector. In a clock tree, the block sits behind an oscillator that supplies the source clock. One of its outputs usually feeds the upstream phase comparator.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A (output bit 0) divides the source clock by 2 when `sel_in[0]` is 0 and by 4 when it is 1. It is high for the first half of each period.
- R2: Bank B (bit 1, `sel_in[1]`), bank C (bits 3:2, `sel_in[2]`) and bank D (bits 8:4, `sel_in[3]`) divide by 4 when their select bit is 0 and by 8 when it is 1. Each is high for the first half of each period.
- R3: On the first source edge after `rst_oe` falls, all nine divided outputs go high together. They all go high together again on every eighth edge after that.
- R4: While `rst_oe` is high, `out_en` is all zeros and `out_clk` is all zeros. Raising `rst_oe` in the middle of a run restarts the phase from the beginning.
- R5: While `rst_oe` is low, `out_en` is all ones.
- R6: A change on `sel_in` takes effect only at the start of the next 8-edge frame. Edges before that keep the ratios already in use.
- R7: When `div_en` is low and `rst_oe` is low, every bit of `out_clk` equals the selected reference clock, with no register in the path.
- R8: With `ref_pick` high, `ref_test` is the selected reference and `ref_main` has no effect. With `ref_pick` low, `ref_main` is selected and `ref_test` has no effect.
- R9: In bypass mode, a high `rst_oe` still forces `out_clk` and `out_en` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock feeding the divider |
| rst_oe | input | 1 | High: reset all state and disable outputs; low: run and enable |
| div_en | input | 1 | High: outputs come from the divider; low: bypass to the reference |
| ref_pick | input | 1 | Reference selector: 1 picks ref_test, 0 picks ref_main |
| ref_test | input | 1 | Test reference clock |
| ref_main | input | 1 | Main reference clock |
| sel_in | input | 4 | Per-bank ratio select: bit 0 A, bit 1 B, bit 2 C, bit 3 D |
| out_clk | output | 9 | Clock outputs: bit 0 A, bit 1 B, bits 3:2 C, bits 8:4 D |
| out_en | output | 9 | Per-output drive enable, low while disabled |

## Verification
The bench builds the block with its default bank sizes: one A, one B, two C and five D outputs. With these sizes every lane index maps to a bank, including the bank boundaries at bits 1/2 and 3/4. A table of select patterns checks each output over a whole 8-edge frame against a phase model kept in the bench. Directed tests then change the selects in the middle of a frame, reset in the middle of a run, and drive each reference leg in bypass, both with reset high and with reset low.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Width of the shared phase counter; its top tap is the slowest ratio.
  localparam int PH_W = 3;

  typedef enum logic [1:0] {
    DIV_2 = 2'd0,
    DIV_4 = 2'd1,
    DIV_8 = 2'd2
  } div_e;

  typedef enum logic [1:0] {
    BK_A = 2'd0,
    BK_B = 2'd1,
    BK_C = 2'd2,
    BK_D = 2'd3
  } bank_e;

  // Ratio chosen by a bank's select bit.
  function automatic div_e ratio_for(bank_e bk, logic sel);
    if (bk == BK_A) return sel ? DIV_4 : DIV_2;
    return sel ? DIV_8 : DIV_4;
  endfunction

  // Output level for a given phase: high in the first half of the period.
  function automatic logic tap_level(logic [PH_W-1:0] ph, div_e d);
    return ~ph[int'(d)];
  endfunction

  // Which bank a flat output index belongs to.
  function automatic bank_e bank_of(int idx, int na, int nb, int nc);
    if (idx < na) return BK_A;
    if (idx < na + nb) return BK_B;
    if (idx < na + nb + nc) return BK_C;
    return BK_D;
  endfunction

endpackage

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
  import clkdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] ph_nxt,
  output logic            frame_start
);

  // Resets to all ones so that the first edge after release is phase 0.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) ph <= '1;
    else     ph <= ph_nxt;
  end

  assign ph_nxt      = ph + PH_W'(1);
  assign frame_start = &ph;

endmodule

// File: rtl/clkdiv_selhold.sv
module clkdiv_selhold #(
  parameter int N_BANK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_BANK-1:0] sel_in,
  input  logic              frame_start,
  output logic [N_BANK-1:0] sel_act,
  output logic [N_BANK-1:0] sel_eff
);

  // New selects are accepted only on the edge that opens a frame.
  assign sel_eff = frame_start ? sel_in : sel_act;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sel_act <= '0;
    else     sel_act <= sel_eff;
  end

endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
  import clkdiv_pkg::*;
#(
  parameter bank_e BANK = BK_A
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph_nxt,
  input  logic            sel_bit,
  output logic            q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= 1'b0;
    else     q <= tap_level(ph_nxt, ratio_for(BANK, sel_bit));
  end

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int N_A = 1,
  parameter int N_B = 1,
  parameter int N_C = 2,
  parameter int N_D = 5,
  localparam int N_OUT  = N_A + N_B + N_C + N_D,
  localparam int N_BANK = 4
) (
  input  logic              src_clk,
  input  logic              rst_oe,
  input  logic              div_en,
  input  logic              ref_pick,
  input  logic              ref_test,
  input  logic              ref_main,
  input  logic [N_BANK-1:0] sel_in,
  output logic [N_OUT-1:0]  out_clk,
  output logic [N_OUT-1:0]  out_en
);

  logic [PH_W-1:0]   ph;
  logic [PH_W-1:0]   ph_nxt;
  logic              frame_start;
  logic [N_BANK-1:0] sel_act;
  logic [N_BANK-1:0] sel_eff;
  logic [N_OUT-1:0]  q_vec;
  logic              ref_clk;

  clkdiv_phase u_phase (
    .clk         (src_clk),
    .rst         (rst_oe),
    .ph          (ph),
    .ph_nxt      (ph_nxt),
    .frame_start (frame_start)
  );

  clkdiv_selhold #(.N_BANK(N_BANK)) u_sel (
    .clk         (src_clk),
    .rst         (rst_oe),
    .sel_in      (sel_in),
    .frame_start (frame_start),
    .sel_act     (sel_act),
    .sel_eff     (sel_eff)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    localparam bank_e BK = bank_of(i, N_A, N_B, N_C);
    clkdiv_lane #(.BANK(BK)) u_lane (
      .clk     (src_clk),
      .rst     (rst_oe),
      .ph_nxt  (ph_nxt),
      .sel_bit (sel_eff[int'(BK)]),
      .q       (q_vec[i])
    );
  end

  assign ref_clk = ref_pick ? ref_test : ref_main;

  always_comb begin
    if (rst_oe)      out_clk = '0;
    else if (div_en) out_clk = q_vec;
    else             out_clk = {N_OUT{ref_clk}};
  end

  assign out_en = {N_OUT{~rst_oe}};

endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk #(
  parameter int N_OUT = 9
) (
  input logic             clk,
  input logic             rst_oe,
  input logic             div_en,
  input logic             ref_pick,
  input logic             ref_test,
  input logic             ref_main,
  input logic [3:0]       sel_act,
  input logic             frame_start,
  input logic [N_OUT-1:0] q_vec,
  input logic [N_OUT-1:0] out_clk,
  input logic [N_OUT-1:0] out_en
);

  // R4: the reset/enable input forces the outputs off.
  always @(posedge clk) begin
    if (rst_oe) begin
      a_r4_off_in_reset: assert (out_en == '0 && out_clk == '0);
    end
  end

  a_r5_enabled: assert property (@(posedge clk) disable iff (rst_oe)
    out_en == {N_OUT{1'b1}});

  a_r3_frame_aligned: assert property (@(posedge clk) disable iff (rst_oe)
    frame_start |=> q_vec == {N_OUT{1'b1}});

  a_r6_sel_held: assert property (@(posedge clk) disable iff (rst_oe)
    !frame_start |=> $stable(sel_act));

  a_r1_half_toggle: assert property (@(posedge clk) disable iff (rst_oe)
    (!frame_start && !sel_act[0]) |=> q_vec[0] != $past(q_vec[0]));

  a_r7_bypass_follow: assert property (@(posedge clk) disable iff (rst_oe)
    !div_en |-> out_clk == {N_OUT{ref_pick ? ref_test : ref_main}});

endmodule

bind clkdiv_banks clkdiv_banks_chk #(.N_OUT(N_OUT)) u_chk (
  .clk         (src_clk),
  .rst_oe      (rst_oe),
  .div_en      (div_en),
  .ref_pick    (ref_pick),
  .ref_test    (ref_test),
  .ref_main    (ref_main),
  .sel_act     (sel_act),
  .frame_start (frame_start),
  .q_vec       (q_vec),
  .out_clk     (out_clk),
  .out_en      (out_en)
);

// File: tb/tb_clkdiv_banks.sv
`timescale 1ns/1ps
module tb_clkdiv_banks;

  logic       clk = 1'b0;
  logic       rst_oe, div_en, ref_pick, ref_test, ref_main;
  logic [3:0] sel_in;
  logic [8:0] out_clk, out_en;

  int n_vec  = 0;
  int n_miss = 0;
  int edge_n = 0;

  always #10 clk = ~clk;

  clkdiv_banks dut (
    .src_clk (clk),
    .rst_oe  (rst_oe),
    .div_en  (div_en),
    .ref_pick(ref_pick),
    .ref_test(ref_test),
    .ref_main(ref_main),
    .sel_in  (sel_in),
    .out_clk (out_clk),
    .out_en  (out_en)
  );

  // Source edges seen since reset was released.
  always @(posedge clk or posedge rst_oe) begin
    if (rst_oe) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  // Row: {sel[3:0], ratio A, ratio B, ratio C, ratio D}
  localparam logic [19:0] VECS [8] = '{
    {4'b0000, 4'd2, 4'd4, 4'd4, 4'd4},
    {4'b1111, 4'd4, 4'd8, 4'd8, 4'd8},
    {4'b0001, 4'd4, 4'd4, 4'd4, 4'd4},
    {4'b0010, 4'd2, 4'd8, 4'd4, 4'd4},
    {4'b0100, 4'd2, 4'd4, 4'd8, 4'd4},
    {4'b1000, 4'd2, 4'd4, 4'd4, 4'd8},
    {4'b0110, 4'd2, 4'd8, 4'd8, 4'd4},
    {4'b1011, 4'd4, 4'd8, 4'd4, 4'd8}
  };

  function automatic logic lvl(int r, int p);
    return ((p & (r >> 1)) == 0);
  endfunction

  function automatic logic [8:0] expect_vec(logic [15:0] rr, int p);
    logic [8:0] v;
    v[0] = lvl(int'(rr[15:12]), p);
    v[1] = lvl(int'(rr[11:8]), p);
    v[2] = lvl(int'(rr[7:4]), p);
    v[3] = v[2];
    for (int k = 4; k < 9; k++) v[k] = lvl(int'(rr[3:0]), p);
    return v;
  endfunction

  function automatic int phase();
    return (edge_n - 1) % 8;
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: got %b expected %b (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  task automatic to_phase(int p);
    do @(negedge clk); while (phase() != p);
  endtask

  initial begin
    #4_000_000;
    n_miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    rst_oe = 1'b1; div_en = 1'b1; ref_pick = 1'b0;
    ref_test = 1'b0; ref_main = 1'b0; sel_in = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R4 reset out_en", out_en, 9'h000);
    chk("R4 reset out_clk", out_clk, 9'h000);
    rst_oe = 1'b0;
    #1;
    chk("R5 enabled", out_en, 9'h1FF);
    @(negedge clk);
    chk("R3 first edge all high", out_clk, 9'h1FF);

    // Table walk: R1/R2 ratios per bank over a whole frame.
    for (int v = 0; v < 8; v++) begin
      sel_in = VECS[v][19:16];
      to_phase(0);
      for (int k = 0; k < 8; k++) begin
        chk((v == 0 || v == 2) ? "R1 bank A ratio" : "R2 bank B/C/D ratio",
            out_clk, expect_vec(VECS[v][15:0], phase()));
        if (k < 7) @(negedge clk);
      end
    end

    // R6: select change in mid-frame waits for the frame boundary.
    to_phase(2);
    sel_in = 4'b0000;
    for (int k = 3; k < 8; k++) begin
      @(negedge clk);
      chk("R6 old ratio kept", out_clk, expect_vec(VECS[7][15:0], phase()));
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R6 new ratio at frame", out_clk, expect_vec(VECS[0][15:0], phase()));
    end

    // R4: reset mid-run restarts the phase.
    to_phase(4);
    rst_oe = 1'b1;
    #1;
    chk("R4 mid reset out_clk", out_clk, 9'h000);
    chk("R4 mid reset out_en", out_en, 9'h000);
    repeat (2) @(negedge clk);
    rst_oe = 1'b0;
    @(negedge clk);
    chk("R3 realign after reset", out_clk, 9'h1FF);
    @(negedge clk);
    chk("R4 phase restarted", out_clk, expect_vec(VECS[0][15:0], 1));

    // R7/R8: bypass with each reference leg.
    div_en = 1'b0; ref_pick = 1'b1; ref_test = 1'b1; ref_main = 1'b0;
    #1 chk("R8 test leg high", out_clk, 9'h1FF);
    ref_test = 1'b0; ref_main = 1'b1;
    #1 chk("R8 main ignored when test picked", out_clk, 9'h000);
    ref_pick = 1'b0;
    #1 chk("R7 bypass main high", out_clk, 9'h1FF);
    ref_test = 1'b1; ref_main = 1'b0;
    #1 chk("R8 test ignored when main picked", out_clk, 9'h000);
    @(negedge clk);
    ref_main = 1'b1;
    #1 chk("R7 bypass follows without clock", out_clk, 9'h1FF);

    // R9: reset still wins in bypass.
    rst_oe = 1'b1;
    #1;
    chk("R9 bypass reset out_clk", out_clk, 9'h000);
    chk("R9 bypass reset out_en", out_en, 9'h000);
    @(negedge clk);
    rst_oe = 1'b0; div_en = 1'b1;
    @(negedge clk);
    chk("R3 divided path back", out_clk, 9'h1FF);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule